// File: doc/BRIEF.md
# Triggered SPI Program Replay Unit

This unit sits in front of an SPI command sequencer and stores two things: a short program of 16-bit sequencer commands and a block of transmit words. Software fills both memories one entry at a time through a plain register write port. It then sets the enable bit. From then on every pulse on the trigger input replays the whole program and the whole transmit block. No software action is needed per transaction, and the stored contents stay in place for the next trigger.

During a replay two independent valid/ready streams run side by side. The command stream delivers every stored command once, starting at entry 0. The data stream delivers every stored transmit word once, also from entry 0. A replay ends when both streams have drained. A status bit shows when a replay is running. A clear register empties both memories so that a new program can be loaded. A read-only capability word reports the log2 depth of each memory.

All registers of the unit sit inside one 32-byte window, so a second unit placed beside it starts 32 bytes further on. The offsets are: control 0x00, status 0x04, clear 0x08, capability 0x0C, command load 0x10, data load 0x14. Any other offset reads as 0.

Top module: `spi_replay_unit`

## Requirements
- R1: After reset, both stream valids are low and control, status and clear read 0. The capability word at 0x0C holds log2 of the command depth in bits [7:0] and log2 of the data depth in bits [15:8]. With the default depths of 16 entries it reads 0x0000_0404.
- R2: Each write to 0x10 appends wr_data[15:0] as the next command. Each write to 0x14 appends wr_data[DAT_W-1:0] as the next transmit word. A replay emits the entries in the order they were written.
- R3: A load write that finds its memory already full is dropped. The first DEPTH entries are kept unchanged.
- R4: Control bit 0 is the enable. A trigger starts a replay only when enable is 1 and no replay is running. A trigger with enable 0 has no effect. Clearing enable during a replay lets that replay run to its end.
- R5: Every replay emits every stored command exactly once and every stored transmit word exactly once, each on its own valid/ready handshake. While valid is high and ready is low, the valid and the data hold steady.
- R6: The stored contents survive a replay. Back-to-back triggers with no reload emit the same sequences again.
- R7: A trigger that arrives while a replay is running is dropped and is not queued. This includes the cycle of the final handshake.
- R8: Status bit 0 at 0x04 reads 1 from the cycle after an accepted trigger until both streams have drained. It then returns to 0. Valid is never high while status is 0.
- R9: Bit 0 of the clear register at 0x08 empties both memories and aborts any replay while it is 1. Writing 1 and then 0 leaves both memories empty. A trigger after that produces no handshakes.
- R10: Load writes are ignored while the enable bit is 1 or a replay is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the write inside the 32-byte window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the read |
| rd_data | output | 32 | Combinational read data |
| trigger | input | 1 | Replay request pulse |
| cmd_valid | output | 1 | Command stream valid |
| cmd_ready | input | 1 | Command stream ready from the sequencer |
| cmd_data | output | 16 | Current command |
| tx_valid | output | 1 | Transmit-data stream valid |
| tx_ready | input | 1 | Transmit-data stream ready |
| tx_data | output | DAT_W (32) | Current transmit word |

## Verification
The two functions that can meet in one cycle are the acceptance of a new trigger and the end of a running replay: a trigger can land in the same clock as the final command handshake. The bench counts clock edges from a trigger it issues, with ready held high, and raises a second trigger exactly on the edge that carries the last command. It then judges that no further handshakes appear and that status drops. A later trigger, issued once the unit is idle, must again produce the full sequence, so that the dropped trigger is not mistaken for a dead unit. Stalls that hold ready low are used in the same way to place a trigger and a disable inside a running replay.

// File: rtl/spi_replay_pkg.sv
package spi_replay_pkg;

  localparam int unsigned ADDR_W = 5;

  // byte offsets inside the 32-byte window of one unit
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CAPS = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_DAT  = 5'h14;

  localparam int unsigned CMD_W = 16;

endpackage

// File: rtl/replay_regs.sv
module replay_regs
  import spi_replay_pkg::*;
#(
  parameter int unsigned CMD_LOG2 = 4,
  parameter int unsigned DAT_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              busy,
  output logic              enable,
  output logic              clear,
  output logic              cmd_push,
  output logic              dat_push,
  output logic [31:0]       rd_data
);

  localparam logic [31:0] CAPS_WORD = {16'd0, 8'(DAT_LOG2), 8'(CMD_LOG2)};

  logic en_q, en_d;
  logic clr_q, clr_d;
  logic load_ok;

  always_comb begin
    en_d  = en_q;
    clr_d = clr_q;
    if (wr_en && (wr_addr == OFS_CTRL)) en_d  = wr_bit;
    if (wr_en && (wr_addr == OFS_CLR))  clr_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      clr_q <= clr_d;
    end
  end

  // loads only while the unit is parked
  assign load_ok  = wr_en && !en_q && !busy && !clr_q;
  assign cmd_push = load_ok && (wr_addr == OFS_CMD);
  assign dat_push = load_ok && (wr_addr == OFS_DAT);
  assign enable   = en_q;
  assign clear    = clr_q;

  always_comb begin
    case (rd_addr)
      OFS_CTRL: rd_data = {31'd0, en_q};
      OFS_STAT: rd_data = {31'd0, busy};
      OFS_CLR:  rd_data = {31'd0, clr_q};
      OFS_CAPS: rd_data = CAPS_WORD;
      default:  rd_data = 32'd0;
    endcase
  end

endmodule

// File: rtl/replay_store.sv
module replay_store #(
  parameter int unsigned W    = 16,
  parameter int unsigned LOG2 = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            push,
  input  logic [W-1:0]    push_data,
  input  logic [LOG2-1:0] rd_idx,
  output logic [W-1:0]    rd_data,
  output logic [LOG2:0]   count
);

  localparam int unsigned DEPTH    = 1 << LOG2;
  localparam logic [LOG2:0] FULL_CNT = (LOG2+1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [LOG2:0] cnt_q, cnt_d;
  logic          full;
  logic          wr_ok;

  assign full  = (cnt_q == FULL_CNT);
  assign wr_ok = push && !full && !clear;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)      cnt_d = '0;
    else if (wr_ok) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // one write enable per entry; entries carry no reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_we;
    assign ent_we = wr_ok && (cnt_q[LOG2-1:0] == LOG2'(g));
    always_ff @(posedge clk) begin
      if (ent_we) mem_q[g] <= push_data;
    end
  end

  assign rd_data = mem_q[rd_idx];
  assign count   = cnt_q;

endmodule

// File: rtl/replay_stream.sv
module replay_stream #(
  parameter int unsigned LOG2 = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            active,
  input  logic [LOG2:0]   count,
  input  logic            ready,
  output logic            valid,
  output logic [LOG2-1:0] idx,
  output logic            done
);

  logic [LOG2:0] ptr_q, ptr_d;
  logic          ptr_en;
  logic          pending;

  assign pending = (ptr_q < count);
  assign valid   = active && pending;
  assign done    = !pending;
  assign ptr_en  = start || (valid && ready);

  always_comb begin
    ptr_d = ptr_q;
    if (start)      ptr_d = '0;
    else if (ptr_en) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign idx = ptr_q[LOG2-1:0];

endmodule

// File: rtl/spi_replay_unit.sv
module spi_replay_unit
  import spi_replay_pkg::*;
#(
  parameter int unsigned CMD_LOG2 = 4,
  parameter int unsigned DAT_LOG2 = 4,
  parameter int unsigned DAT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              trigger,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DAT_W-1:0]  tx_data
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic                enable, clear;
  logic                cmd_push, dat_push;
  logic                busy_q, busy_d;
  logic                start;
  logic [CMD_LOG2:0]   cmd_cnt;
  logic [DAT_LOG2:0]   dat_cnt;
  logic [CMD_LOG2-1:0] cmd_idx;
  logic [DAT_LOG2-1:0] dat_idx;
  logic                cmd_done, dat_done;

  replay_regs #(
    .CMD_LOG2(CMD_LOG2),
    .DAT_LOG2(DAT_LOG2)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_bit  (wr_data[0]),
    .rd_addr (rd_addr),
    .busy    (busy_q),
    .enable  (enable),
    .clear   (clear),
    .cmd_push(cmd_push),
    .dat_push(dat_push),
    .rd_data (rd_data)
  );

  replay_store #(
    .W   (CMD_W),
    .LOG2(CMD_LOG2)
  ) u_cmd_mem (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (clear),
    .push     (cmd_push),
    .push_data(wr_data[CMD_W-1:0]),
    .rd_idx   (cmd_idx),
    .rd_data  (cmd_data),
    .count    (cmd_cnt)
  );

  replay_store #(
    .W   (DAT_W),
    .LOG2(DAT_LOG2)
  ) u_dat_mem (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clear    (clear),
    .push     (dat_push),
    .push_data(wr_data[DAT_W-1:0]),
    .rd_idx   (dat_idx),
    .rd_data  (tx_data),
    .count    (dat_cnt)
  );

  replay_stream #(.LOG2(CMD_LOG2)) u_cmd_str (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .active(busy_q),
    .count (cmd_cnt),
    .ready (cmd_ready),
    .valid (cmd_valid),
    .idx   (cmd_idx),
    .done  (cmd_done)
  );

  replay_stream #(.LOG2(DAT_LOG2)) u_dat_str (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .active(busy_q),
    .count (dat_cnt),
    .ready (tx_ready),
    .valid (tx_valid),
    .idx   (dat_idx),
    .done  (dat_done)
  );

  // replay sequencer
  assign start = trigger && enable && !busy_q && !clear;

  always_comb begin
    busy_d = busy_q;
    if (clear)                              busy_d = 1'b0;
    else if (start)                         busy_d = 1'b1;
    else if (busy_q && cmd_done && dat_done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) busy_q <= 1'b0;
    else             busy_q <= busy_d;
  end

endmodule

// File: rtl/spi_replay_chk.sv
module spi_replay_chk #(
  parameter int unsigned CMD_LOG2 = 4,
  parameter int unsigned DAT_LOG2 = 4,
  parameter int unsigned DAT_W    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trigger,
  input logic                enable,
  input logic                clear,
  input logic                busy,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic [15:0]         cmd_data,
  input logic                tx_valid,
  input logic                tx_ready,
  input logic [DAT_W-1:0]    tx_data,
  input logic [CMD_LOG2-1:0] cmd_idx,
  input logic [CMD_LOG2:0]   cmd_cnt,
  input logic [DAT_LOG2:0]   dat_cnt
);

  localparam logic [CMD_LOG2:0] CMD_MAX = (CMD_LOG2+1)'(1 << CMD_LOG2);
  localparam logic [DAT_LOG2:0] DAT_MAX = (DAT_LOG2+1)'(1 << DAT_LOG2);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready && !clear) |=> (cmd_valid && $stable(cmd_data))); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !clear) |=> (tx_valid && $stable(tx_data))); // R5
  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || tx_valid) |-> busy); // R8
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trigger && !(cmd_valid && cmd_ready)) |=> $stable(cmd_idx)); // R7
  AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !busy) |=> !busy); // R4
  AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !clear) |=> (cmd_cnt == $past(cmd_cnt) && dat_cnt == $past(dat_cnt))); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cnt <= CMD_MAX) && (dat_cnt <= DAT_MAX)); // R3
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cmd_cnt == '0 && dat_cnt == '0 && !busy)); // R9

endmodule

bind spi_replay_unit spi_replay_chk #(
  .CMD_LOG2(CMD_LOG2),
  .DAT_LOG2(DAT_LOG2),
  .DAT_W   (DAT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .trigger  (trigger),
  .enable   (enable),
  .clear    (clear),
  .busy     (busy_q),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_data (cmd_data),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .cmd_idx  (cmd_idx),
  .cmd_cnt  (cmd_cnt),
  .dat_cnt  (dat_cnt)
);

// File: tb/test_spi_replay_unit.sv
`timescale 1ns/1ps
module test_spi_replay_unit;

  localparam int DEPTH = 16;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_CLR = 5'h08,
                         A_CAPS = 5'h0C, A_CMD = 5'h10, A_DAT = 5'h14;

  logic        clk, rst_n;
  logic        wr_en;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        trigger;
  logic        cmd_valid, cmd_ready, tx_valid, tx_ready;
  logic [15:0] cmd_data;
  logic [31:0] tx_data;

  spi_replay_unit i_spi_replay_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trigger(trigger),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  int checks = 0, errors = 0;
  int rmode = 0;
  int cyc = 0;
  bit finished = 0;
  logic [15:0] got_cmd [64];
  logic [31:0] got_tx  [64];
  int got_cmd_n = 0, got_tx_n = 0;

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  // expected contents, computed from the program number and entry index
  function automatic logic [15:0] ecmd(int k, int i);
    return 16'((k * 16'h0b3d) ^ (i * 16'h0111) ^ 16'h5a00);
  endfunction
  function automatic logic [31:0] edat(int k, int i);
    return 32'(k * 32'h0001_0007 + i * 32'h0100_0301 + 32'hC0DE_0000);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // handshake monitor, sampled mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid && cmd_ready) begin
        if (got_cmd_n < 64) got_cmd[got_cmd_n] = cmd_data;
        got_cmd_n++;
      end
      if (rst_n && tx_valid && tx_ready) begin
        if (got_tx_n < 64) got_tx[got_tx_n] = tx_data;
        got_tx_n++;
      end
    end
  end

  // ready patterns: 0 always, 1 and 2 irregular, 3 stalled
  initial begin
    cmd_ready = 1'b0;
    tx_ready  = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      case (rmode)
        0: begin cmd_ready = 1'b1; tx_ready = 1'b1; end
        1: begin cmd_ready = (cyc % 3) != 0; tx_ready = (cyc % 2) == 0; end
        2: begin cmd_ready = (cyc % 4) >= 2; tx_ready = (cyc % 5) != 1; end
        default: begin cmd_ready = 1'b0; tx_ready = 1'b0; end
      endcase
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL all watchdog act=%0h exp=%0h", cyc, 0);
    summary();
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk);
    #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk);
    #1 rd_addr = a;
    #0.5 d = rd_data;
  endtask

  task automatic pulse();
    @(posedge clk);
    #1 trigger = 1'b1;
    @(posedge clk);
    #1 trigger = 1'b0;
  endtask

  task automatic clr_mon();
    got_cmd_n = 0;
    got_tx_n  = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int t = 0; t < 600; t++) begin
      rd(A_STAT, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic wipe();
    wr(A_CLR, 32'd1);
    wr(A_CLR, 32'd0);
  endtask

  task automatic load(input int k, input int n, input int m);
    for (int i = 0; i < n; i++) wr(A_CMD, {16'hFFFF, ecmd(k, i)});
    for (int i = 0; i < m; i++) wr(A_DAT, edat(k, i));
  endtask

  task automatic compare(input int k, input int n, input int m, input string req);
    chk(got_cmd_n == n, req, "command count", got_cmd_n, n);
    chk(got_tx_n == m, req, "data count", got_tx_n, m);
    for (int i = 0; i < n && i < got_cmd_n && i < 64; i++)
      chk(got_cmd[i] == ecmd(k, i), req, "command value", got_cmd[i], ecmd(k, i));
    for (int i = 0; i < m && i < got_tx_n && i < 64; i++)
      chk(got_tx[i] == edat(k, i), req, "data value", got_tx[i], edat(k, i));
  endtask

  task automatic replay(input int k, input int n, input int m, input string req);
    clr_mon();
    pulse();
    wait_idle();
    repeat (3) @(posedge clk);
    compare(k, n, m, req);
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; trigger = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state and capability word
    #1;
    chk(!cmd_valid && !tx_valid, "R1", "valids after reset", {cmd_valid, tx_valid}, 0);
    rd(A_CTRL, v); chk(v == 0, "R1", "control after reset", v, 0);
    rd(A_STAT, v); chk(v == 0, "R1", "status after reset", v, 0);
    rd(A_CLR, v);  chk(v == 0, "R1", "clear after reset", v, 0);
    rd(A_CAPS, v); chk(v == 32'h0000_0404, "R1", "capability", v, 32'h0000_0404);
    rd(5'h18, v);  chk(v == 0, "R1", "unused offset", v, 0);

    // R2 R5: sweep program length 0..16 with varying data length and ready patterns
    for (int k = 0; k <= DEPTH; k++) begin
      int m;
      m = (k * 7) % (DEPTH + 1);
      rmode = k % 3;
      wipe();
      load(k, k, m);
      wr(A_CTRL, 32'd1);
      replay(k, k, m, "R2");
      // R6 second trigger, no reload
      replay(k, k, m, "R6");
      wr(A_CTRL, 32'd0);
    end
    rmode = 0;

    // R3 overfill both memories
    wipe();
    load(40, DEPTH + 3, DEPTH + 4);
    wr(A_CTRL, 32'd1);
    replay(40, DEPTH, DEPTH, "R3");
    wr(A_CTRL, 32'd0);

    // R10 load writes while enabled are dropped
    wipe();
    load(41, 5, 2);
    wr(A_CTRL, 32'd1);
    wr(A_CMD, 32'h0000_DEAD);
    wr(A_DAT, 32'hBAD0_BAD0);
    replay(41, 5, 2, "R10");

    // R8 status during a stalled replay; R7 trigger during it is dropped
    rmode = 3;
    clr_mon();
    pulse();
    repeat (4) @(posedge clk);
    rd(A_STAT, v); chk(v[0] == 1'b1, "R8", "status while running", v, 1);
    chk(got_cmd_n == 0, "R5", "no handshake while stalled", got_cmd_n, 0);
    pulse();
    // R4 disable mid-replay lets it finish
    wr(A_CTRL, 32'd0);
    rmode = 1;
    wait_idle();
    repeat (3) @(posedge clk);
    compare(41, 5, 2, "R7");
    rd(A_STAT, v); chk(v[0] == 1'b0, "R8", "status after drain", v, 0);

    // R10 load while a replay runs with enable already low is dropped
    wr(A_CTRL, 32'd1);
    rmode = 3;
    clr_mon();
    pulse();
    wr(A_CTRL, 32'd0);
    wr(A_CMD, 32'h0000_BEEF);
    rmode = 0;
    wait_idle();
    repeat (3) @(posedge clk);
    compare(41, 5, 2, "R10");

    // R4 trigger while disabled
    clr_mon();
    pulse();
    repeat (2) @(posedge clk);
    rd(A_STAT, v); chk(v[0] == 1'b0, "R4", "status with enable low", v, 0);
    repeat (20) @(posedge clk);
    chk(got_cmd_n == 0 && got_tx_n == 0, "R4", "handshakes with enable low", got_cmd_n, 0);

    // R7 trigger on the edge of the final handshake (3 commands, ready high)
    wipe();
    load(42, 3, 0);
    wr(A_CTRL, 32'd1);
    rmode = 0;
    repeat (2) @(posedge clk);
    clr_mon();
    @(posedge clk);
    #1 trigger = 1'b1;              // accepted on edge E1
    @(posedge clk);
    #1 trigger = 1'b0;
    repeat (2) @(posedge clk);      // now just after E3
    #1 trigger = 1'b1;              // seen on E4, the last handshake
    @(posedge clk);
    #1 trigger = 1'b0;
    repeat (30) @(posedge clk);
    compare(42, 3, 0, "R7");
    rd(A_STAT, v); chk(v[0] == 1'b0, "R7", "idle after coincident trigger", v, 0);
    // idle again: a new trigger is taken
    replay(42, 3, 0, "R6");

    // R9 clear empties both memories; replay then emits nothing
    wr(A_CTRL, 32'd0);
    wr(A_CLR, 32'd1);
    rd(A_CLR, v); chk(v[0] == 1'b1, "R9", "clear bit reads back", v, 1);
    wr(A_CMD, 32'h0000_1111);
    wr(A_CLR, 32'd0);
    wr(A_CTRL, 32'd1);
    replay(0, 0, 0, "R9");

    // R9 clear aborts a stalled replay
    wr(A_CTRL, 32'd0);
    load(43, 4, 4);
    wr(A_CTRL, 32'd1);
    rmode = 3;
    clr_mon();
    pulse();
    wr(A_CLR, 32'd1);
    repeat (2) @(posedge clk);
    rd(A_STAT, v); chk(v[0] == 1'b0, "R9", "status after clear", v, 0);
    chk(!cmd_valid && !tx_valid, "R9", "valids after clear", {cmd_valid, tx_valid}, 0);
    wr(A_CLR, 32'd0);
    rmode = 0;
    replay(0, 0, 0, "R9");

    summary();
  end

endmodule